// File: doc/BRIEF.md
# Dual-Lane Byte/Word Shared Memory

This block is a unified code-and-data store made of two byte-wide banks. Both banks share one word address decoder, and each has its own 8-bit data lane. It has two ports. The fetch port takes a word address and always returns a complete 16-bit word. The data port is driven by a 16-bit data pointer and can work in word mode or byte mode.

In word mode the pointer is the word address. In byte mode, pointer bits 15:1 form the word address and bit 0 picks a lane: 0 is the low byte (bits 7:0) and 1 is the high byte (bits 15:8). So bytes 2n and 2n+1 together make up word n.

Every read fetches the whole word. A byte read then routes the chosen lane to the data output and fills the upper 8 bits with zeros. A byte write enables only the chosen bank and leaves the other bank untouched. All pointer bits take part in decoding. A pointer whose word address lies beyond the array is a miss: the write is dropped, or the read returns zero, and it never aliases onto a lower word.

A small response state machine holds the kind of data read issued in the previous cycle. It has five states:
- `RSP_IDLE`: no read is pending.
- `RSP_WORD`: a word read is pending.
- `RSP_LO`: a low-byte read is pending.
- `RSP_HI`: a high-byte read is pending.
- `RSP_MISS`: an out-of-range read is pending.

On every clock the machine moves to the state that matches the current data request. A write, or no request, leads to `RSP_IDLE`. The output logic uses the state to steer the registered word onto `data_rdata`.

Top module: `twin_lane_ram`

## Requirements
- R1: While reset is asserted, `fetch_data`, `data_rdata` and `data_rvalid` are all zero.
- R2: One cycle after `fetch_en` is high, `fetch_data` holds the full 16-bit word at `fetch_addr`. While `fetch_en` is low, `fetch_data` holds its value.
- R3: A word-mode access (`data_byte`=0) uses `data_ptr` as the word address. A write stores all of `data_wdata`, and a read returns the whole word on `data_rdata`.
- R4: A byte-mode read with pointer bit 0 = 0 returns bits 7:0 of word `data_ptr[15:1]` on `data_rdata[7:0]`, with `data_rdata[15:8]` = 0.
- R5: A byte-mode read with pointer bit 0 = 1 returns bits 15:8 of word `data_ptr[15:1]` on `data_rdata[7:0]`, with `data_rdata[15:8]` = 0.
- R6: A byte-mode write stores `data_wdata[7:0]` into the lane chosen by pointer bit 0 only. The other byte of that word keeps its value, and `data_wdata[15:8]` is ignored.
- R7: Byte pointers 2n and 2n+1 address the low and high bytes of word n. The result of writing them is seen as one word by both the data port and the fetch port.
- R8: All 16 pointer bits are decoded. If the word address is 2^WORD_AW or greater, a write has no effect on any word, and a read returns 0 with `data_rvalid` still asserted.
- R9: If a fetch and a data write target the same word in the same cycle, the fetch returns the old contents. The new contents are visible from the next fetch on.
- R10: `data_rvalid` is high exactly in the cycle after a data read request (`data_en`=1, `data_we`=0) and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Fetch request |
| fetch_addr | input | WORD_AW | Fetch word address |
| fetch_data | output | 16 | Fetched word, one cycle after request |
| data_en | input | 1 | Data access request |
| data_we | input | 1 | 1 = write, 0 = read |
| data_byte | input | 1 | 1 = byte mode, 0 = word mode |
| data_ptr | input | PTR_W | Data pointer |
| data_wdata | input | 16 | Write data (byte mode uses bits 7:0) |
| data_rdata | output | 16 | Read result, byte reads zero-extended |
| data_rvalid | output | 1 | Read result valid |

## Verification
The bound checker follows several properties on every cycle:
- reset quiescence;
- `data_rvalid` following each read request by exactly one cycle;
- the upper byte being zero after any byte read;
- zero data after any out-of-range read;
- the fetch output holding while idle.

Other behaviour depends on stored contents, so only the bench's scenarios can show it: correct lane steering, one bank staying intact under a byte write, the 2n/2n+1 pairing, no aliasing of high pointers, and old data returned on a fetch/write collision. For these the bench keeps a byte-level model and compares every result against it.

// File: rtl/tlr_pkg.sv
package tlr_pkg;

    typedef enum logic [2:0] {
        RSP_IDLE = 3'd0,
        RSP_WORD = 3'd1,
        RSP_LO   = 3'd2,
        RSP_HI   = 3'd3,
        RSP_MISS = 3'd4
    } rsp_e;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;

endpackage

// File: rtl/tlr_decode.sv
module tlr_decode
    import tlr_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int WORD_AW = 8
) (
    input  logic               data_en,
    input  logic               data_we,
    input  logic               data_byte,
    input  logic [PTR_W-1:0]   data_ptr,
    output logic [WORD_AW-1:0] word_idx,
    output logic [LANES-1:0]   lane_we,
    output logic               rd_hit,
    output rsp_e               next_rsp
);

    logic [PTR_W-1:0] wide_addr;
    logic             in_range;

    always_comb begin
        wide_addr = data_byte ? {1'b0, data_ptr[PTR_W-1:1]} : data_ptr;
        in_range  = (wide_addr >> WORD_AW) == '0;
        word_idx  = wide_addr[WORD_AW-1:0];

        lane_we[0] = data_en && data_we && in_range && (!data_byte || !data_ptr[0]);
        lane_we[1] = data_en && data_we && in_range && (!data_byte ||  data_ptr[0]);
        rd_hit     = data_en && !data_we && in_range;

        if (!data_en || data_we)  next_rsp = RSP_IDLE;
        else if (!in_range)       next_rsp = RSP_MISS;
        else if (!data_byte)      next_rsp = RSP_WORD;
        else if (data_ptr[0])     next_rsp = RSP_HI;
        else                      next_rsp = RSP_LO;
    end

endmodule

// File: rtl/tlr_bank.sv
module tlr_bank
    import tlr_pkg::*;
#(
    parameter int WORD_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [WORD_AW-1:0] waddr,
    input  logic [LANE_W-1:0]  wdata,
    input  logic               fetch_rd,
    input  logic [WORD_AW-1:0] fetch_idx,
    output logic [LANE_W-1:0]  fetch_q,
    input  logic               data_rd,
    input  logic [WORD_AW-1:0] data_idx,
    output logic [LANE_W-1:0]  data_q
);

    localparam int DEPTH = 1 << WORD_AW;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_q <= '0;
            data_q  <= '0;
        end else begin
            if (fetch_rd) fetch_q <= cells[fetch_idx];
            if (data_rd)  data_q  <= cells[data_idx];
        end
    end

endmodule

// File: rtl/tlr_steer.sv
module tlr_steer
    import tlr_pkg::*;
(
    input  rsp_e        rsp,
    input  logic [15:0] word_q,
    output logic [15:0] rdata,
    output logic        rvalid
);

    always_comb begin
        rvalid = 1'b1;
        rdata  = '0;
        unique case (rsp)
            RSP_IDLE: rvalid = 1'b0;
            RSP_WORD: rdata  = word_q;
            RSP_LO:   rdata  = {8'h00, word_q[7:0]};
            RSP_HI:   rdata  = {8'h00, word_q[15:8]};
            RSP_MISS: rdata  = '0;
            default:  rvalid = 1'b0;
        endcase
    end

endmodule

// File: rtl/twin_lane_ram.sv
module twin_lane_ram
    import tlr_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int WORD_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_en,
    input  logic [WORD_AW-1:0] fetch_addr,
    output logic [15:0]        fetch_data,
    input  logic               data_en,
    input  logic               data_we,
    input  logic               data_byte,
    input  logic [PTR_W-1:0]   data_ptr,
    input  logic [15:0]        data_wdata,
    output logic [15:0]        data_rdata,
    output logic               data_rvalid
);

    logic [WORD_AW-1:0] word_idx;
    logic [LANES-1:0]   lane_we;
    logic               rd_hit;
    rsp_e               next_rsp;
    rsp_e               rsp_q;
    logic [15:0]        data_word;
    logic [LANE_W-1:0]  lane_wdata [LANES];

    tlr_decode #(.PTR_W(PTR_W), .WORD_AW(WORD_AW)) u_dec (
        .data_en   (data_en),
        .data_we   (data_we),
        .data_byte (data_byte),
        .data_ptr  (data_ptr),
        .word_idx  (word_idx),
        .lane_we   (lane_we),
        .rd_hit    (rd_hit),
        .next_rsp  (next_rsp)
    );

    assign lane_wdata[0] = data_wdata[7:0];
    assign lane_wdata[1] = data_byte ? data_wdata[7:0] : data_wdata[15:8];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tlr_bank #(.WORD_AW(WORD_AW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (lane_we[g]),
            .waddr     (word_idx),
            .wdata     (lane_wdata[g]),
            .fetch_rd  (fetch_en),
            .fetch_idx (fetch_addr),
            .fetch_q   (fetch_data[g*LANE_W +: LANE_W]),
            .data_rd   (rd_hit),
            .data_idx  (word_idx),
            .data_q    (data_word[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= RSP_IDLE;
        else        rsp_q <= next_rsp;
    end

    tlr_steer u_steer (
        .rsp    (rsp_q),
        .word_q (data_word),
        .rdata  (data_rdata),
        .rvalid (data_rvalid)
    );

endmodule

// File: rtl/tlr_checker.sv
module tlr_checker #(
    parameter int PTR_W   = 16,
    parameter int WORD_AW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_en,
    input logic [15:0]      fetch_data,
    input logic             data_en,
    input logic             data_we,
    input logic             data_byte,
    input logic [PTR_W-1:0] data_ptr,
    input logic [15:0]      data_rdata,
    input logic             data_rvalid
);

    logic [PTR_W-1:0] chk_wide;
    logic             chk_miss;
    logic             chk_rd;

    assign chk_wide = data_byte ? (data_ptr >> 1) : data_ptr;
    assign chk_miss = (chk_wide >> WORD_AW) != '0;
    assign chk_rd   = data_en && !data_we;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (fetch_data == '0 && data_rdata == '0 && !data_rvalid));

    a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        chk_rd |=> data_rvalid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_rd |=> !data_rvalid);

    // R4 and R5
    a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_rd && data_byte) |=> data_rdata[15:8] == 8'h00);

    a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_rd && chk_miss) |=> data_rdata == '0);

    a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> $stable(fetch_data));

endmodule

bind twin_lane_ram tlr_checker #(.PTR_W(PTR_W), .WORD_AW(WORD_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_en    (fetch_en),
    .fetch_data  (fetch_data),
    .data_en     (data_en),
    .data_we     (data_we),
    .data_byte   (data_byte),
    .data_ptr    (data_ptr),
    .data_rdata  (data_rdata),
    .data_rvalid (data_rvalid)
);

// File: tb/twin_lane_ram_test.sv
`timescale 1ns/1ps
module twin_lane_ram_test;

    localparam int PTR_W   = 16;
    localparam int WORD_AW = 8;
    localparam int DEPTH   = 1 << WORD_AW;

    typedef struct {
        int          due;
        logic [15:0] val;
        string       req;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fetch_en = 1'b0;
    logic [WORD_AW-1:0] fetch_addr = '0;
    logic [15:0]        fetch_data;
    logic               data_en = 1'b0;
    logic               data_we = 1'b0;
    logic               data_byte = 1'b0;
    logic [PTR_W-1:0]   data_ptr = '0;
    logic [15:0]        data_wdata = '0;
    logic [15:0]        data_rdata;
    logic               data_rvalid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [7:0] m_lo [DEPTH];
    logic [7:0] m_hi [DEPTH];
    exp_t dq[$];
    exp_t fq[$];

    twin_lane_ram #(.PTR_W(PTR_W), .WORD_AW(WORD_AW)) uut (.*);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one request cycle on both ports
    task automatic op(input logic f_en, input logic [WORD_AW-1:0] f_addr,
                      input logic d_en, input logic d_we, input logic d_byte,
                      input logic [15:0] ptr, input logic [15:0] wd, input string req);
        logic [15:0] wide;
        logic        hit;
        logic [WORD_AW-1:0] idx;
        logic [15:0] exp;
        wide = d_byte ? {1'b0, ptr[15:1]} : ptr;
        hit  = (wide >> WORD_AW) == 0;
        idx  = wide[WORD_AW-1:0];
        if (f_en) fq.push_back('{cyc + 1, {m_hi[f_addr], m_lo[f_addr]}, req});
        if (d_en && !d_we) begin
            if (!hit)        exp = 16'h0;
            else if (!d_byte) exp = {m_hi[idx], m_lo[idx]};
            else if (ptr[0]) exp = {8'h0, m_hi[idx]};
            else             exp = {8'h0, m_lo[idx]};
            dq.push_back('{cyc + 1, exp, req});
        end
        if (d_en && d_we && hit) begin
            if (!d_byte) begin m_lo[idx] = wd[7:0]; m_hi[idx] = wd[15:8]; end
            else if (ptr[0]) m_hi[idx] = wd[7:0];
            else             m_lo[idx] = wd[7:0];
        end
        fetch_en = f_en; fetch_addr = f_addr;
        data_en = d_en; data_we = d_we; data_byte = d_byte;
        data_ptr = ptr; data_wdata = wd;
        @(negedge clk);
        fetch_en = 1'b0; data_en = 1'b0;
    endtask

    task automatic wr(input logic b, input logic [15:0] p, input logic [15:0] d, input string r);
        op(1'b0, '0, 1'b1, 1'b1, b, p, d, r);
    endtask
    task automatic rd(input logic b, input logic [15:0] p, input string r);
        op(1'b0, '0, 1'b1, 1'b0, b, p, 16'h0, r);
    endtask
    task automatic fe(input logic [WORD_AW-1:0] a, input string r);
        op(1'b1, a, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, r);
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dq.size() > 0 && dq[0].due == cyc) begin
                exp_t e;
                e = dq.pop_front();
                check({e.req, " rvalid"}, {15'h0, data_rvalid}, 16'h1);
                check({e.req, " data"}, data_rdata, e.val);
            end else if (data_rvalid) begin
                fails++; checks++;
                $display("FAIL R10: actual rvalid 1 expected 0");
            end
            if (fq.size() > 0 && fq[0].due == cyc) begin
                exp_t f;
                f = fq.pop_front();
                check({f.req, " fetch"}, fetch_data, f.val);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 fetch", fetch_data, 16'h0);
        check("R1 rdata", data_rdata, 16'h0);
        check("R1 rvalid", {15'h0, data_rvalid}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 word writes and reads
        wr(0, 16'h0010, 16'hA55A, "R3");
        wr(0, 16'h0011, 16'h1234, "R3");
        wr(0, 16'h0020, 16'hBEEF, "R3");
        wr(0, 16'h00FF, 16'hC3C3, "R3");
        wr(0, 16'h0005, 16'h5555, "R3");
        rd(0, 16'h0010, "R3");
        rd(0, 16'h0011, "R3");
        rd(0, 16'h00FF, "R3");

        // R2 fetch full words, then idle hold
        fe(8'h10, "R2");
        fe(8'h11, "R2");
        fe(8'hFF, "R2");
        @(negedge clk);
        check("R2 hold", fetch_data, 16'hC3C3);

        // R4 / R5 byte reads
        rd(1, 16'h0020, "R4");
        rd(1, 16'h0021, "R5");
        rd(1, 16'h01FF, "R5");

        // R6 byte writes leave the other lane intact
        wr(1, 16'h0022, 16'hAB77, "R6");
        rd(0, 16'h0011, "R6");
        wr(1, 16'h0023, 16'hFF99, "R6");
        rd(0, 16'h0011, "R6");

        // R7 byte pair forms one word
        wr(1, 16'h0040, 16'h0011, "R7");
        wr(1, 16'h0041, 16'h0022, "R7");
        rd(0, 16'h0020, "R7");
        fe(8'h20, "R7");

        // R8 no aliasing, misses read zero
        wr(0, 16'h0105, 16'hDEAD, "R8");
        wr(1, 16'h020A, 16'h00EE, "R8");
        rd(0, 16'h0005, "R8");
        rd(0, 16'h0105, "R8");
        rd(1, 16'h020B, "R8");
        rd(1, 16'hFFFF, "R8");

        // R9 collision returns old word
        op(1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 16'h0010, 16'h0F0F, "R9");
        fe(8'h10, "R9");

        // R10 back-to-back reads, then write with no response
        rd(0, 16'h0020, "R10");
        rd(1, 16'h0041, "R10");
        wr(0, 16'h0030, 16'h4242, "R10");
        @(negedge clk);
        @(negedge clk);

        done = 1;
        if (dq.size() != 0 || fq.size() != 0) begin
            fails++; checks++;
            $display("FAIL R10: actual %0d pending expected 0", dq.size() + fq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule